// File: doc/BRIEF.md
# Load-Use Stall Control Unit

This block decides, every cycle, whether the front of a five-stage in-order pipeline has to pause for one cycle. The case it handles is a load that is in the execute stage while the next instruction in decode reads the register that load will write. Forwarding cannot supply that value in time, because the data only exists after the memory stage. A single bubble is therefore needed.

When the condition holds, the unit holds the program counter and the fetch/decode pipeline register. It also raises a select that clears every control field entering the execute/decode boundary register, so a no-op travels on through EX, MEM and WB while those later stages keep moving. One cycle later the load has moved on to MEM and the condition drops. From that point the forwarding paths supply the loaded value. The unit is purely combinational and sits between the decode-stage register fields and the pipeline's write enables.

Top module: `ldu_stall_ctrl`

## Requirements
- R1: When `ex_is_load` is 1, `ex_dst` is nonzero and `ex_dst` equals `id_src_a`, then `bubble_sel` is 1, `pc_wr_en` is 0 and `ifid_wr_en` is 0.
- R2: When `ex_is_load` is 1, `ex_dst` is nonzero and `ex_dst` equals `id_src_b`, then `bubble_sel` is 1, `pc_wr_en` is 0 and `ifid_wr_en` is 0.
- R3: When `ex_is_load` is 0, no stall is raised: `bubble_sel` is 0 and both write enables are 1, whatever the register fields hold.
- R4: A load whose destination is register 0 never causes a stall, even when a decode source is also 0.
- R5: A load whose destination matches neither decode source causes no stall.
- R6: `pc_wr_en` and `ifid_wr_en` are always equal and always the inverse of `bubble_sel`.
- R7: When both decode sources match the load destination, the outputs are exactly those of a single match (one stall, not two).
- R8: In a running pipeline, a load followed immediately by a consumer of its destination costs exactly one stall cycle, and the stall clears in the next cycle. A consumer two or more instructions behind a load never stalls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_is_load | input | 1 | Execute-stage instruction reads data memory (is a load) |
| ex_dst | input | REG_W | Destination register of the execute-stage instruction |
| id_src_a | input | REG_W | First source register field of the decode-stage instruction |
| id_src_b | input | REG_W | Second source register field of the decode-stage instruction |
| pc_wr_en | output | 1 | Program counter write enable; 0 holds the PC |
| ifid_wr_en | output | 1 | Fetch/decode register write enable; 0 holds its contents |
| bubble_sel | output | 1 | 1 forces all control fields entering execute to zero |

## Verification
The hardest situation to reach from the ports is the sequence-level behaviour: a stall followed by exactly one clean cycle, after which the held consumer proceeds and the load's own successors do not stall again. The bench wraps the unit in a small behavioural pipeline that applies the enables and the bubble select to its own fetch/decode and decode/execute registers. It runs a fixed program that puts loads directly before consumers, two slots before consumers, and onto register 0. It then checks the stall pattern cycle by cycle and the total stall count. Seeded random field patterns, with narrow register values so that matches are frequent, cover the combinational cases in between.

// File: rtl/ldu_pkg.sv
package ldu_pkg;

  // Number of source register fields carried by a decode-stage instruction.
  localparam int unsigned SRC_CNT = 2;

  // Index of each source within the packed source vector.
  localparam int unsigned SRC_A = 0;
  localparam int unsigned SRC_B = 1;

  // Stall decision grouped as it is handed to the pipeline.
  typedef struct packed {
    logic pc_wr;
    logic ifid_wr;
    logic bubble;
  } stall_ctl_t;

endpackage

// File: rtl/ldu_src_match.sv
module ldu_src_match #(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned SRC_CNT = 2
) (
  input  logic [REG_W-1:0]              dst,
  input  logic [SRC_CNT-1:0][REG_W-1:0] srcs,
  output logic [SRC_CNT-1:0]            hit
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic dst_live;

  // Register 0 is hard-wired; a write to it never produces a dependency.
  assign dst_live = (dst != ZERO_REG);

  for (genvar g = 0; g < SRC_CNT; g++) begin : g_cmp
    assign hit[g] = dst_live && (srcs[g] == dst);
  end

endmodule

// File: rtl/ldu_stall_gen.sv
module ldu_stall_gen
  import ldu_pkg::*;
#(
  parameter int unsigned SRC_CNT = 2
) (
  input  logic               is_load,
  input  logic [SRC_CNT-1:0] hit,
  output stall_ctl_t         ctl
);

  logic need_stall;

  // Any matching source is enough; several matches still mean one bubble.
  assign need_stall = is_load && (|hit);

  always_comb begin
    ctl.pc_wr   = !need_stall;
    ctl.ifid_wr = !need_stall;
    ctl.bubble  = need_stall;
  end

endmodule

// File: rtl/ldu_stall_ctrl.sv
module ldu_stall_ctrl
  import ldu_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] ex_dst,
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  output logic             pc_wr_en,
  output logic             ifid_wr_en,
  output logic             bubble_sel
);

  logic [SRC_CNT-1:0][REG_W-1:0] src_vec;
  logic [SRC_CNT-1:0]            src_hit;
  stall_ctl_t                    ctl;

  always_comb begin
    src_vec        = '0;
    src_vec[SRC_A] = id_src_a;
    src_vec[SRC_B] = id_src_b;
  end

  ldu_src_match #(
    .REG_W   (REG_W),
    .SRC_CNT (SRC_CNT)
  ) u_match (
    .dst  (ex_dst),
    .srcs (src_vec),
    .hit  (src_hit)
  );

  ldu_stall_gen #(
    .SRC_CNT (SRC_CNT)
  ) u_gen (
    .is_load (ex_is_load),
    .hit     (src_hit),
    .ctl     (ctl)
  );

  assign pc_wr_en   = ctl.pc_wr;
  assign ifid_wr_en = ctl.ifid_wr;
  assign bubble_sel = ctl.bubble;

endmodule

// File: rtl/ldu_stall_chk.sv
module ldu_stall_chk #(
  parameter int unsigned REG_W = 5
) (
  input logic             ex_is_load,
  input logic [REG_W-1:0] ex_dst,
  input logic [REG_W-1:0] id_src_a,
  input logic [REG_W-1:0] id_src_b,
  input logic             pc_wr_en,
  input logic             ifid_wr_en,
  input logic             bubble_sel
);

  logic known;
  assign known = !$isunknown({ex_is_load, ex_dst, id_src_a, id_src_b,
                              pc_wr_en, ifid_wr_en, bubble_sel});

  always_comb begin
    if (known) begin
      p_src_a_stall_r1: assert (!(ex_is_load && ex_dst != '0 && ex_dst == id_src_a) || bubble_sel)
        else $error("R1 load matching first source did not stall");
      p_src_b_stall_r2: assert (!(ex_is_load && ex_dst != '0 && ex_dst == id_src_b) || bubble_sel)
        else $error("R2 load matching second source did not stall");
      p_no_load_r3: assert (ex_is_load || !bubble_sel)
        else $error("R3 stall raised without a load");
      p_zero_dst_r4: assert ((ex_dst != '0) || !bubble_sel)
        else $error("R4 stall raised for register 0");
      p_no_match_r5: assert (ex_dst == id_src_a || ex_dst == id_src_b || !bubble_sel)
        else $error("R5 stall raised without a matching source");
      p_gates_agree_r6: assert (pc_wr_en == ifid_wr_en && pc_wr_en == !bubble_sel)
        else $error("R6 write enables disagree with bubble select");
    end
  end

endmodule

bind ldu_stall_ctrl ldu_stall_chk #(.REG_W(REG_W)) u_chk (
  .ex_is_load (ex_is_load),
  .ex_dst     (ex_dst),
  .id_src_a   (id_src_a),
  .id_src_b   (id_src_b),
  .pc_wr_en   (pc_wr_en),
  .ifid_wr_en (ifid_wr_en),
  .bubble_sel (bubble_sel)
);

// File: tb/sim_ldu_stall_ctrl.sv
`timescale 1ns/1ps
module sim_ldu_stall_ctrl;

  localparam int unsigned REG_W = 5;
  localparam int PROG_N = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic             ex_is_load;
  logic [REG_W-1:0] ex_dst;
  logic [REG_W-1:0] id_src_a;
  logic [REG_W-1:0] id_src_b;
  logic             pc_wr_en;
  logic             ifid_wr_en;
  logic             bubble_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  ldu_stall_ctrl #(.REG_W(REG_W)) u0 (
    .ex_is_load (ex_is_load),
    .ex_dst     (ex_dst),
    .id_src_a   (id_src_a),
    .id_src_b   (id_src_b),
    .pc_wr_en   (pc_wr_en),
    .ifid_wr_en (ifid_wr_en),
    .bubble_sel (bubble_sel)
  );

  function automatic bit exp_stall(input bit ld, input logic [REG_W-1:0] d,
                                   input logic [REG_W-1:0] a, input logic [REG_W-1:0] b);
    return ld && (d != 0) && (d == a || d == b);
  endfunction

  task automatic check_out(input string req, input bit stall);
    checks++;
    if (bubble_sel !== stall || pc_wr_en !== !stall || ifid_wr_en !== !stall) begin
      errors++;
      $display("FAIL %s: got bubble=%b pc=%b ifid=%b, expected bubble=%b pc=%b ifid=%b",
               req, bubble_sel, pc_wr_en, ifid_wr_en, stall, !stall, !stall);
    end
  endtask

  task automatic apply(input bit ld, input int d, input int a, input int b, input string req);
    @(posedge clk);
    #1;
    ex_is_load = ld;
    ex_dst     = REG_W'(d);
    id_src_a   = REG_W'(a);
    id_src_b   = REG_W'(b);
    @(negedge clk);
    check_out(req, exp_stall(ld, REG_W'(d), REG_W'(a), REG_W'(b)));
  endtask

  // Program for the pipeline model: load flag, destination, sources.
  bit             p_ld [PROG_N];
  logic [REG_W-1:0] p_d [PROG_N];
  logic [REG_W-1:0] p_a [PROG_N];
  logic [REG_W-1:0] p_b [PROG_N];

  task automatic set_instr(input int i, input bit ld, input int d, input int a, input int b);
    p_ld[i] = ld; p_d[i] = REG_W'(d); p_a[i] = REG_W'(a); p_b[i] = REG_W'(b);
  endtask

  task automatic run_pipeline();
    int pc = 0;
    bit ifid_ld = 0;  logic [REG_W-1:0] ifid_d = '0, ifid_a = '0, ifid_b = '0;
    bit idex_ld = 0;  logic [REG_W-1:0] idex_d = '0;
    int stalls = 0;
    bit prev_stall = 0;
    set_instr(0, 1, 2, 1, 0);   // load r2
    set_instr(1, 0, 12, 2, 5);  // uses r2 on first source: one stall
    set_instr(2, 0, 13, 6, 2);  // two behind the load: no stall
    set_instr(3, 1, 4, 3, 0);   // load r4
    set_instr(4, 0, 7, 7, 4);   // uses r4 on second source: one stall
    set_instr(5, 1, 0, 1, 0);   // load into r0
    set_instr(6, 0, 8, 0, 0);   // reads r0: no stall
    set_instr(7, 1, 9, 1, 0);   // load r9
    set_instr(8, 0, 3, 3, 1);   // independent: no stall
    set_instr(9, 0, 14, 9, 9);  // two behind load r9: no stall
    for (int cyc = 0; cyc < PROG_N + 8; cyc++) begin
      @(posedge clk);
      #1;
      ex_is_load = idex_ld; ex_dst = idex_d; id_src_a = ifid_a; id_src_b = ifid_b;
      @(negedge clk);
      begin
        bit st = exp_stall(idex_ld, idex_d, ifid_a, ifid_b);
        check_out("R8 pipeline cycle", st);
        if (prev_stall && bubble_sel) begin
          checks++; errors++;
          $display("FAIL R8: stall repeated in cycle %0d, got 1 expected 0", cyc);
        end
        prev_stall = bubble_sel;
        if (bubble_sel) stalls++;
        // Advance the model using the unit's outputs.
        if (bubble_sel) begin
          idex_ld = 0; idex_d = '0;
        end else begin
          idex_ld = ifid_ld; idex_d = ifid_d;
        end
        if (ifid_wr_en) begin
          if (pc < PROG_N) begin
            ifid_ld = p_ld[pc]; ifid_d = p_d[pc]; ifid_a = p_a[pc]; ifid_b = p_b[pc];
          end else begin
            ifid_ld = 0; ifid_d = '0; ifid_a = '0; ifid_b = '0;
          end
        end
        if (pc_wr_en) pc++;
      end
    end
    checks++;
    if (stalls != 2) begin
      errors++;
      $display("FAIL R8: total stall cycles got %0d expected 2", stalls);
    end
    checks++;
    if (pc != PROG_N + 8 - 2) begin
      errors++;
      $display("FAIL R8: fetch count got %0d expected %0d", pc, PROG_N + 6);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused = $urandom(32'h1d5a);
    ex_is_load = 0; ex_dst = '0; id_src_a = '0; id_src_b = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_out("R3 idle after reset", 0);

    apply(1, 2, 2, 5, "R1 first source match");
    apply(1, 31, 4, 31, "R2 second source match");
    apply(0, 2, 2, 2, "R3 not a load");
    apply(1, 0, 0, 0, "R4 zero destination");
    apply(1, 0, 0, 7, "R4 zero destination one source");
    apply(1, 6, 5, 7, "R5 no match");
    apply(1, 9, 9, 9, "R7 both sources match");
    apply(1, 1, 1, 0, "R1 lowest nonzero register");

    for (int i = 0; i < 300; i++) begin
      int span = (i < 150) ? 4 : 32;
      apply(bit'($urandom_range(0, 1)), int'($urandom_range(0, span - 1)),
            int'($urandom_range(0, span - 1)), int'($urandom_range(0, span - 1)),
            "R6 random pattern");
    end

    run_pipeline();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule